// File: doc/BRIEF.md
# NAND Flash Host Bus Bridge

This block lets a byte-wide, memory-mapped host bus drive one 8-bit raw NAND flash device. The host picks the levels of the flash latch-enable lines and the chip-enable line by writing a small control register. It then writes one byte to a command/address register, and the block turns that byte into a single timed write strobe on the flash bus. Page data goes through a 2 KiB linear window. Each byte access in the window becomes one flash read or write cycle, with both latch-enable lines low.

A status register shows four things: whether a flash cycle is still in flight, whether the flash reports ready, whether the last command/address byte has finished, and a sticky flag for a ready edge. The flash ready/busy input passes through a synchronizer before it reaches that register. Setup, strobe and hold times are parameters counted in clock cycles.

Host accesses that need a flash cycle are held off through the `host_ready` handshake while an earlier cycle is still running. Register accesses complete at once.

Top module: `nand_bus_if`

## Requirements
- R1: After reset the chip-enable output `nf_ce_n` is 1, the latch enables are low, both strobes are high, `nf_io_oe` is low, the control register reads 0x01 and every status bit that reflects internal state is 0.
- R2: A write to any even offset from 0x800 to 0x80E stores `host_wdata[4:0]` in the control register: bit 0 chip disable, bit 1 command latch, bit 2 address latch, bit 3 ready-interrupt mask, bit 4 ready-edge flag enable. A read of any of these offsets returns the register with bits 7:5 zero. `nf_ce_n` follows bit 0 from the next cycle.
- R3: A write to any odd offset from 0x801 to 0x80F issues one flash write cycle. `nf_io_out` carries the byte, and `nf_cle` and `nf_ale` carry control bits 1 and 2 as they were when the write was accepted.
- R4: A write to an offset below 0x800 issues one flash write cycle of that byte with `nf_cle` and `nf_ale` low.
- R5: A read of an offset below 0x800 issues one flash read cycle with both latch enables low. `nf_io_in` is sampled in the last cycle of the low `nf_re_n` pulse, and the byte is returned on `host_rdata` in the cycle in which `host_ready` rises, which is the last hold cycle.
- R6: Every flash cycle lasts T_SETUP cycles with both strobes high and bus and latches valid, then T_STROBE cycles with exactly one strobe low, then T_HOLD cycles with both strobes high. The two strobes are never low together.
- R7: Status bit 2 (offset 0x810) is 1 from the cycle after a flash cycle is accepted through the last hold cycle. Outside a flash cycle both strobes are high and `nf_io_oe` is low.
- R8: A write that needs a flash cycle is accepted in the cycle it is presented when no flash cycle is running. While one is running, `host_ready` stays low for any access that needs a flash cycle.
- R9: Status bit 3 equals `nf_rb_n` delayed through two flip-flops.
- R10: Status bit 1 clears when a command/address write is accepted and sets when that flash cycle ends. Data-window cycles leave it unchanged.
- R11: Status bit 0 sets when the synchronized ready level rises while control bit 4 is 1, and it clears when the status register is read. A rise while bit 4 is 0 does not set it, and a set in the same cycle as the read wins.
- R12: Accesses to the control register, the status register or any other offset complete in the cycle they are presented. Reads of the command/address register and of unmapped offsets return 0. Writes to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host access request, held until `host_ready` |
| host_we | input | 1 | 1 for write, 0 for read |
| host_addr | input | 12 | Byte offset within the block |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Read byte, valid when `host_ready` is high |
| host_ready | output | 1 | Access completes in this cycle |
| nf_ce_n | output | 1 | Flash chip enable, active low |
| nf_cle | output | 1 | Flash command latch enable |
| nf_ale | output | 1 | Flash address latch enable |
| nf_we_n | output | 1 | Flash write strobe, active low |
| nf_re_n | output | 1 | Flash read strobe, active low |
| nf_io_out | output | 8 | Flash bus output byte |
| nf_io_oe | output | 1 | Flash bus output enable |
| nf_io_in | input | 8 | Flash bus input byte |
| nf_rb_n | input | 1 | Flash ready (1) / busy (0) |

## Verification
A wrong phase counter shows at the flash pins in the same cycle: a strobe edge moves, or the strobe pulse gets shorter or longer. A lost busy flag shows in the next cycle as a host write accepted on top of a running cycle. A stale latch-enable copy puts the wrong CLE or ALE level on the pins during the setup phase, before any strobe edge. The sticky status bits and the synchronizer delay only show up when the status register is read. The stimulus therefore reads status right after every kind of cycle and after every change of the ready input.

// File: rtl/nand_bus_pkg.sv
package nand_bus_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 8;
    localparam int CTL_W  = 5;

    localparam logic [ADDR_W-1:0] WINDOW_END = 12'h800;
    localparam logic [ADDR_W-1:0] REG_BASE   = 12'h800;
    localparam logic [ADDR_W-1:0] STS_ADDR   = 12'h810;

    // control register bits
    localparam int CB_CE   = 0;
    localparam int CB_CLE  = 1;
    localparam int CB_ALE  = 2;
    localparam int CB_MASK = 3;
    localparam int CB_EDGE = 4;

    localparam logic [CTL_W-1:0] CTL_RESET = 5'b00001;

    typedef enum logic [2:0] {
        RG_WINDOW,
        RG_CTL,
        RG_CMDADDR,
        RG_STATUS,
        RG_NONE
    } region_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD
    } phase_e;

    typedef struct packed {
        logic              is_rd;
        logic              cle;
        logic              ale;
        logic [DATA_W-1:0] data;
    } cyc_req_t;

    function automatic region_e region_of(input logic [ADDR_W-1:0] a);
        if (a < WINDOW_END)
            return RG_WINDOW;
        else if (a[ADDR_W-1:4] == REG_BASE[ADDR_W-1:4])
            return a[0] ? RG_CMDADDR : RG_CTL;
        else if (a == STS_ADDR)
            return RG_STATUS;
        else
            return RG_NONE;
    endfunction

endpackage

// File: rtl/nbi_addr_decode.sv
module nbi_addr_decode
    import nand_bus_pkg::*;
(
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic              flash_wr,
    output logic              flash_rd
);
    always_comb begin
        region   = region_of(addr);
        flash_wr = req && we && (region == RG_WINDOW || region == RG_CMDADDR);
        flash_rd = req && !we && (region == RG_WINDOW);
    end
endmodule

// File: rtl/nbi_cycle_engine.sv
module nbi_cycle_engine
    import nand_bus_pkg::*;
#(
    parameter int T_SETUP  = 2,
    parameter int T_STROBE = 2,
    parameter int T_HOLD   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  cyc_req_t          req_in,
    input  logic [DATA_W-1:0] io_in,
    output logic              busy,
    output logic              done,
    output logic              done_rd,
    output logic [DATA_W-1:0] rd_byte,
    output logic              we_n,
    output logic              re_n,
    output logic              cle,
    output logic              ale,
    output logic              io_oe,
    output logic [DATA_W-1:0] io_out
);
    localparam int T_MAX0 = (T_SETUP > T_STROBE) ? T_SETUP : T_STROBE;
    localparam int T_MAX  = (T_MAX0 > T_HOLD) ? T_MAX0 : T_HOLD;
    localparam int CNT_W  = $clog2(T_MAX + 1);
    localparam logic [CNT_W-1:0] LD_SETUP  = CNT_W'(T_SETUP - 1);
    localparam logic [CNT_W-1:0] LD_STROBE = CNT_W'(T_STROBE - 1);
    localparam logic [CNT_W-1:0] LD_HOLD   = CNT_W'(T_HOLD - 1);

    phase_e           ph;
    logic [CNT_W-1:0] cnt;
    cyc_req_t         cur;
    logic             last;

    assign last = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph      <= PH_IDLE;
            cnt     <= '0;
            cur     <= '0;
            rd_byte <= '0;
        end else begin
            unique case (ph)
                PH_IDLE: begin
                    if (start) begin
                        ph  <= PH_SETUP;
                        cnt <= LD_SETUP;
                        cur <= req_in;
                    end
                end
                PH_SETUP: begin
                    if (last) begin
                        ph  <= PH_STROBE;
                        cnt <= LD_STROBE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_STROBE: begin
                    if (last) begin
                        ph  <= PH_HOLD;
                        cnt <= LD_HOLD;
                        if (cur.is_rd)
                            rd_byte <= io_in;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_HOLD: begin
                    if (last)
                        ph <= PH_IDLE;
                    else
                        cnt <= cnt - 1'b1;
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        busy    = (ph != PH_IDLE);
        done    = (ph == PH_HOLD) && last;
        done_rd = done && cur.is_rd;
        we_n    = !((ph == PH_STROBE) && !cur.is_rd);
        re_n    = !((ph == PH_STROBE) && cur.is_rd);
        cle     = busy && cur.cle;
        ale     = busy && cur.ale;
        io_oe   = busy && !cur.is_rd;
        io_out  = cur.data;
    end
endmodule

// File: rtl/nbi_sync.sv
module nbi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/nand_bus_if.sv
module nand_bus_if
    import nand_bus_pkg::*;
#(
    parameter int T_SETUP     = 2,
    parameter int T_STROBE    = 2,
    parameter int T_HOLD      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_ready,
    output logic              nf_ce_n,
    output logic              nf_cle,
    output logic              nf_ale,
    output logic              nf_we_n,
    output logic              nf_re_n,
    output logic [DATA_W-1:0] nf_io_out,
    output logic              nf_io_oe,
    input  logic [DATA_W-1:0] nf_io_in,
    input  logic              nf_rb_n
);
    region_e           region;
    logic              flash_wr, flash_rd;
    logic              eng_busy, eng_done, eng_done_rd, start;
    logic [DATA_W-1:0] rd_byte;
    cyc_req_t          cyc_req;
    logic [CTL_W-1:0]  ctl_q;
    logic              cmd_inflight, cmd_done_q, edge_flag_q;
    logic              rdy_sync, rdy_prev, rdy_rise, accept;

    nbi_addr_decode u_dec (
        .req      (host_req),
        .we       (host_we),
        .addr     (host_addr),
        .region   (region),
        .flash_wr (flash_wr),
        .flash_rd (flash_rd)
    );

    always_comb begin
        cyc_req.is_rd = !host_we;
        cyc_req.cle   = (region == RG_CMDADDR) && ctl_q[CB_CLE];
        cyc_req.ale   = (region == RG_CMDADDR) && ctl_q[CB_ALE];
        cyc_req.data  = host_wdata;
    end

    assign start = (flash_wr || flash_rd) && !eng_busy;

    nbi_cycle_engine #(
        .T_SETUP  (T_SETUP),
        .T_STROBE (T_STROBE),
        .T_HOLD   (T_HOLD)
    ) u_eng (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .req_in  (cyc_req),
        .io_in   (nf_io_in),
        .busy    (eng_busy),
        .done    (eng_done),
        .done_rd (eng_done_rd),
        .rd_byte (rd_byte),
        .we_n    (nf_we_n),
        .re_n    (nf_re_n),
        .cle     (nf_cle),
        .ale     (nf_ale),
        .io_oe   (nf_io_oe),
        .io_out  (nf_io_out)
    );

    nbi_sync #(.STAGES(SYNC_STAGES)) u_rb_sync (
        .clk (clk),
        .rst (rst),
        .d   (nf_rb_n),
        .q   (rdy_sync)
    );

    always_comb begin
        if (flash_wr)      host_ready = !eng_busy;
        else if (flash_rd) host_ready = eng_done_rd;
        else               host_ready = 1'b1;
    end

    assign accept   = host_req && host_ready;
    assign rdy_rise = rdy_sync && !rdy_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q        <= CTL_RESET;
            cmd_inflight <= 1'b0;
            cmd_done_q   <= 1'b0;
            edge_flag_q  <= 1'b0;
            rdy_prev     <= 1'b0;
        end else begin
            rdy_prev <= rdy_sync;
            if (accept && host_we && region == RG_CTL)
                ctl_q <= host_wdata[CTL_W-1:0];
            if (start && region == RG_CMDADDR) begin
                cmd_inflight <= 1'b1;
                cmd_done_q   <= 1'b0;
            end else if (eng_done && cmd_inflight) begin
                cmd_inflight <= 1'b0;
                cmd_done_q   <= 1'b1;
            end
            if (rdy_rise && ctl_q[CB_EDGE])
                edge_flag_q <= 1'b1;
            else if (accept && !host_we && region == RG_STATUS)
                edge_flag_q <= 1'b0;
        end
    end

    always_comb begin
        unique case (region)
            RG_WINDOW: host_rdata = rd_byte;
            RG_CTL:    host_rdata = {{(DATA_W-CTL_W){1'b0}}, ctl_q};
            RG_STATUS: host_rdata = {4'b0000, rdy_sync, eng_busy, cmd_done_q, edge_flag_q};
            default:   host_rdata = '0;
        endcase
    end

    assign nf_ce_n = ctl_q[CB_CE];
endmodule

// File: rtl/nand_bus_if_chk.sv
module nand_bus_if_chk
    import nand_bus_pkg::*;
#(
    parameter int T_STROBE = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              host_req,
    input logic              host_we,
    input logic [ADDR_W-1:0] host_addr,
    input logic [DATA_W-1:0] host_wdata,
    input logic              host_ready,
    input logic              nf_ce_n,
    input logic              nf_cle,
    input logic              nf_ale,
    input logic              nf_we_n,
    input logic              nf_re_n,
    input logic              nf_io_oe,
    input logic              eng_busy
);
    logic [7:0] low_run;

    always_ff @(posedge clk) begin
        if (rst)          low_run <= '0;
        else if (nf_we_n) low_run <= '0;
        else              low_run <= low_run + 8'd1;
    end

    p_strobe_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(!nf_we_n && !nf_re_n));

    p_low_width_r6: assert property (@(posedge clk) disable iff (rst)
        (nf_we_n && low_run != 8'd0) |-> (low_run == 8'(T_STROBE)));

    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        !eng_busy |-> (nf_we_n && nf_re_n && !nf_io_oe));

    p_read_latch_low_r5: assert property (@(posedge clk) disable iff (rst)
        !nf_re_n |-> (!nf_cle && !nf_ale));

    p_ce_follow_r2: assert property (@(posedge clk) disable iff (rst)
        (host_req && host_we && host_ready && host_addr[11:4] == 8'h80 && !host_addr[0])
        |=> (nf_ce_n == $past(host_wdata[0])));

    p_stall_r8: assert property (@(posedge clk) disable iff (rst)
        (host_req && host_we && host_addr < 12'h800 && eng_busy) |-> !host_ready);
endmodule

bind nand_bus_if nand_bus_if_chk #(.T_STROBE(T_STROBE)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_req   (host_req),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_ready (host_ready),
    .nf_ce_n    (nf_ce_n),
    .nf_cle     (nf_cle),
    .nf_ale     (nf_ale),
    .nf_we_n    (nf_we_n),
    .nf_re_n    (nf_re_n),
    .nf_io_oe   (nf_io_oe),
    .eng_busy   (eng_busy)
);

// File: tb/nand_bus_if_tb.sv
module nand_bus_if_tb;
    localparam int TS = 2, TP = 2, TH = 2, TT = TS + TP + TH;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_req = 1'b0, host_we = 1'b0;
    logic [11:0] host_addr = '0;
    logic [7:0] host_wdata = '0, host_rdata;
    logic       host_ready;
    logic       nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_io_oe;
    logic [7:0] nf_io_out;
    logic [7:0] nf_io_in = 8'h00;
    logic       nf_rb_n = 1'b1;

    int tests = 0, fails = 0, cycles = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    nand_bus_if u_dut (
        .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_ready(host_ready), .nf_ce_n(nf_ce_n), .nf_cle(nf_cle), .nf_ale(nf_ale),
        .nf_we_n(nf_we_n), .nf_re_n(nf_re_n), .nf_io_out(nf_io_out),
        .nf_io_oe(nf_io_oe), .nf_io_in(nf_io_in), .nf_rb_n(nf_rb_n)
    );

    // ---------------- reference model ----------------
    int       m_e = -1;            // elapsed cycles of the flash cycle, -1 idle
    bit       m_rdk, m_cmdk, m_cle, m_ale, m_cc, m_flag, m_syp;
    bit [7:0] m_byte, m_rdq;
    bit [4:0] m_ctl = 5'b00001;
    bit       m_sync [$] = '{1'b0, 1'b0};

    // 0 window, 1 control, 2 cmd/addr, 3 status, 4 unmapped
    function automatic int area(input logic [11:0] a);
        if (a < 12'h800) return 0;
        if (a <= 12'h80F) return (a % 2 == 1) ? 2 : 1;
        if (a == 12'h810) return 3;
        return 4;
    endfunction

    function automatic bit exp_ready();
        int  ar = area(host_addr);
        if (host_we && (ar == 0 || ar == 2)) return m_e < 0;
        if (!host_we && ar == 0) return (m_e == TT - 1) && m_rdk;
        return 1'b1;
    endfunction

    function automatic bit [7:0] exp_rdata();
        case (area(host_addr))
            0: return m_rdq;
            1: return {3'b000, m_ctl};
            3: return {4'b0000, m_sync[0], m_e >= 0, m_cc, m_flag};
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk) begin : model
        bit busy, done, rise, fl;
        int ar;
        if (rst) begin
            m_e = -1; m_ctl = 5'b00001; m_cc = 0; m_flag = 0; m_syp = 0;
            m_sync = '{1'b0, 1'b0}; m_rdq = 0; m_byte = 0;
            m_rdk = 0; m_cmdk = 0; m_cle = 0; m_ale = 0;
        end else begin
            busy = m_e >= 0;
            done = busy && m_e == TT - 1;
            ar   = area(host_addr);
            rise = m_sync[0] && !m_syp;
            fl   = host_req && ((host_we && (ar == 0 || ar == 2)) || (!host_we && ar == 0));
            if (busy && m_rdk && m_e == TS + TP - 1) m_rdq = nf_io_in;
            if (done && m_cmdk) m_cc = 1;
            if (rise && m_ctl[4]) m_flag = 1;
            else if (host_req && !host_we && ar == 3) m_flag = 0;
            m_syp = m_sync[0];
            void'(m_sync.pop_front());
            m_sync.push_back(nf_rb_n);
            if (busy) m_e = done ? -1 : m_e + 1;
            if (fl && !busy) begin
                m_e = 0; m_rdk = !host_we; m_cmdk = (ar == 2); m_byte = host_wdata;
                m_cle = (ar == 2) && m_ctl[1];
                m_ale = (ar == 2) && m_ctl[2];
                if (ar == 2) m_cc = 0;
            end
            if (host_req && host_we && ar == 1) m_ctl = host_wdata[4:0];
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at t=%0t", tag, act, exp, $time);
        end
    endtask

    // compare pins every cycle, and the handshake before each edge
    always @(negedge clk) begin : compare
        bit act, strobe;
        if (!rst) begin
            act    = m_e >= 0;
            strobe = act && m_e >= TS && m_e < TS + TP;
            chk(nf_ce_n == m_ctl[0], "R2 nf_ce_n", nf_ce_n, m_ctl[0]);
            chk(nf_we_n == !(strobe && !m_rdk), "R6 nf_we_n", nf_we_n, !(strobe && !m_rdk));
            chk(nf_re_n == !(strobe && m_rdk), "R5 R6 nf_re_n", nf_re_n, !(strobe && m_rdk));
            chk(nf_cle == (act && m_cle), "R3 R4 nf_cle", nf_cle, act && m_cle);
            chk(nf_ale == (act && m_ale), "R3 R4 nf_ale", nf_ale, act && m_ale);
            chk(nf_io_oe == (act && !m_rdk), "R7 nf_io_oe", nf_io_oe, act && !m_rdk);
            if (act && !m_rdk)
                chk(nf_io_out == m_byte, "R3 R4 nf_io_out", nf_io_out, m_byte);
            #3;
            if (host_req) begin
                chk(host_ready == exp_ready(), "R8 R12 host_ready", host_ready, exp_ready());
                if (!host_we && exp_ready())
                    chk(host_rdata == exp_rdata(), "R1 R7 R9 R10 R11 host_rdata",
                        host_rdata, exp_rdata());
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic access(input bit we, input logic [11:0] a, input logic [7:0] d,
                          output logic [7:0] rd);
        bit got;
        @(negedge clk); #1;
        host_req = 1; host_we = we; host_addr = a; host_wdata = d;
        forever begin
            #1; got = host_ready; rd = host_rdata;
            @(negedge clk); #1;
            if (got) break;
        end
        host_req = 0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        logic [7:0] unused;
        access(1'b1, a, d, unused);
    endtask

    task automatic rd(input logic [11:0] a, output logic [7:0] v);
        access(1'b0, a, 8'h00, v);
    endtask

    task automatic poll_idle();
        logic [7:0] s;
        do rd(12'h810, s); while (s[2]);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000 && !finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        #1 rst = 0;
        // R1: reset values checked through the model
        rd(12'h800, v);
        rd(12'h810, v);
        // R2 control register aliases
        wr(12'h80E, 8'hFF);
        rd(12'h808, v);
        wr(12'h802, 8'h02);                // CLE, chip selected
        // R3 command byte, R10 completion, R7 busy polling
        wr(12'h803, 8'h90);
        rd(12'h810, v);
        poll_idle();
        rd(12'h810, v);
        // address bytes with ALE, last two back to back (R8 stall)
        wr(12'h804, 8'h04);
        wr(12'h805, 8'h11);
        poll_idle();
        wr(12'h80F, 8'h22);
        wr(12'h801, 8'h33);
        // control write while a cycle runs; the latched CLE/ALE must hold
        wr(12'h809, 8'h44);
        wr(12'h800, 8'h02);
        poll_idle();
        // R4 data window writes at both ends, back to back
        wr(12'h800, 8'h00);
        wr(12'h000, 8'hA1);
        wr(12'h7FF, 8'h5E);
        // R5 data reads, one queued behind a write
        nf_io_in = 8'hA5;
        rd(12'h123, v);
        wr(12'h010, 8'h77);
        nf_io_in = 8'h3C;
        rd(12'h7FF, v);
        rd(12'h810, v);                    // R10 unchanged by data cycles
        // R11 ready edge flag disabled, then enabled
        nf_rb_n = 0; repeat (4) @(negedge clk);
        nf_rb_n = 1; repeat (4) @(negedge clk);
        rd(12'h810, v);
        wr(12'h800, 8'h10);
        nf_rb_n = 0; repeat (3) @(negedge clk);
        rd(12'h810, v);                    // R9 ready low seen
        nf_rb_n = 1; repeat (4) @(negedge clk);
        rd(12'h810, v);                    // flag set
        rd(12'h810, v);                    // flag cleared by read
        // R12 unmapped and cmd/addr register reads
        wr(12'h9AB, 8'hFF);
        rd(12'h9AB, v);
        rd(12'h803, v);
        rd(12'h800, v);
        repeat (10) @(negedge clk);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule